// File: doc/BRIEF.md
# Flag-Conditional ALU Execute Unit

This unit forms the write-back value for the arithmetic and immediate-move instructions of a 16-bit, eight-register machine. A sequencer hands it the instruction word together with the two register values read from the fields at bits [11:9] and [8:6]. In the same cycle it returns the result, the index of the register to write and a write strobe. Register-register add and NAND can each be made conditional on the carry or zero flag through a two-bit condition code. The carry and zero flags are held inside the unit and update on the clock edge that ends an executing instruction.

The result path is purely combinational. The two flags are the only state. They feed back into the condition test of the next instruction and are also brought out as ports. Register storage, memory traffic and program-counter handling are left to the surrounding core.

Top module: `cond_alu_exec`

## Requirements
- R1: Opcode 0000 (bits [15:12]) drives `result` with the 16-bit sum of `opA` and `opB` and sets `dstIdx` to bits [5:3]. Bit 2 of the word has no effect on any output.
- R2: Opcode 0010 drives `result` with the bitwise NAND of `opA` and `opB`, with `dstIdx` taken from bits [5:3].
- R3: For opcodes 0000 and 0010, condition bits [1:0] control the write. Values 00 and 11 always write, 10 writes only when `carryFlag` is 1, and 01 writes only when `zeroFlag` is 1. A failed condition holds `regWe` low and leaves both flags unchanged.
- R4: Opcode 0001 drives `result` with `opA` plus bits [5:0] sign-extended to 16 bits, with `dstIdx` taken from bits [8:6]. Both flags are left unchanged.
- R5: Opcode 0011 drives `result` with bits [8:0] in result bits [15:7] and zeros in bits [6:0], with `dstIdx` taken from bits [11:9].
- R6: Opcode 1010 drives `result` with bits [8:0] zero-extended to 16 bits, with `dstIdx` taken from bits [11:9].
- R7: Opcode 1011 passes `opB` unchanged to `result`, with `dstIdx` taken from bits [11:9].
- R8: A register-register add that writes loads `carryFlag` with the carry out of bit 15 at the next rising clock edge. No other operation changes `carryFlag`.
- R9: A register-register add or NAND that writes sets `zeroFlag` at the next rising edge when its 16-bit result is zero, and clears it otherwise.
- R10: With `instValid` low, or with any opcode outside those listed above, `regWe` is 0 and both flags keep their values.
- R11: While `rstN` is low, both flags are cleared, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags update on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the flags |
| instValid | input | 1 | The instruction word executes in this cycle |
| instWord | input | 16 | Instruction word |
| opA | input | 16 | Value of the register named in bits [11:9] |
| opB | input | 16 | Value of the register named in bits [8:6] |
| result | output | 16 | Value to write back |
| dstIdx | output | 3 | Index of the destination register |
| regWe | output | 1 | Register write strobe |
| carryFlag | output | 1 | Registered carry flag |
| zeroFlag | output | 1 | Registered zero flag |

## Verification
The only internal state is the flag pair, and a wrong flag shows up in two ways. It is visible directly on `carryFlag` and `zeroFlag` one edge after the instruction that produced it. It also shows up in the same cycle as a wrong `regWe` on the next conditional add or NAND. The stimulus therefore chains instructions, so that each flag written by one step is consumed by the condition test of the next. It also checks that the immediate forms and the failed-condition cases leave the flags exactly as they were. Result-path faults, such as a wrong extension or field selection, are visible on `result` and `dstIdx` within the cycle the word is applied.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

  localparam int DATA_W  = 16;
  localparam int IDX_W   = 3;
  localparam int OP_W    = 4;
  localparam int IMM_S_W = 6;
  localparam int IMM_L_W = 9;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_RR = 4'b0000,
    OP_ADD_IM = 4'b0001,
    OP_NAND   = 4'b0010,
    OP_HI_IM  = 4'b0011,
    OP_ZX_IM  = 4'b1010,
    OP_MOVE   = 4'b1011
  } opcode_e;

  typedef enum logic [1:0] {
    CC_ALWAYS = 2'b00,
    CC_ZERO   = 2'b01,
    CC_CARRY  = 2'b10,
    CC_ALT    = 2'b11
  } cond_e;

  // One-hot selection of the value placed on the result bus
  typedef struct packed {
    logic addRR;
    logic nandRR;
    logic addImm;
    logic hiImm;
    logic zeroImm;
    logic moveReg;
  } res_sel_t;

  // Strobes from control to datapath and flag register
  typedef struct packed {
    res_sel_t          resSel;
    logic              writeEn;
    logic              updCarry;
    logic              updZero;
    logic [IDX_W-1:0]  dstIdx;
  } exec_strobes_t;

endpackage

// File: rtl/cond_alu_ctrl.sv
module cond_alu_ctrl
  import cond_alu_pkg::*;
(
  input  logic                       instValid,
  input  logic [DATA_W-1:0]          instWord,
  input  logic                       carryFlag,
  input  logic                       zeroFlag,
  output exec_strobes_t              strobes
);

  logic [OP_W-1:0]  opField;
  logic [IDX_W-1:0] fieldHi;
  logic [IDX_W-1:0] fieldMid;
  logic [IDX_W-1:0] fieldLo;
  logic [1:0]       condField;
  logic             unusedSpare;
  logic             condPass;
  logic             isRegReg;

  assign opField     = instWord[DATA_W-1 -: OP_W];
  assign fieldHi     = instWord[DATA_W-OP_W-1 -: IDX_W];
  assign fieldMid    = instWord[DATA_W-OP_W-IDX_W-1 -: IDX_W];
  assign fieldLo     = instWord[DATA_W-OP_W-2*IDX_W-1 -: IDX_W];
  assign condField   = instWord[1:0];
  assign unusedSpare = instWord[2];

  always_comb begin
    unique case (cond_e'(condField))
      CC_CARRY: condPass = carryFlag;
      CC_ZERO:  condPass = zeroFlag;
      default:  condPass = 1'b1;
    endcase
  end

  always_comb begin
    strobes          = '0;
    isRegReg         = 1'b0;
    case (opField)
      OP_ADD_RR: begin
        strobes.resSel.addRR = 1'b1;
        strobes.dstIdx       = fieldLo;
        isRegReg             = 1'b1;
      end
      OP_NAND: begin
        strobes.resSel.nandRR = 1'b1;
        strobes.dstIdx        = fieldLo;
        isRegReg              = 1'b1;
      end
      OP_ADD_IM: begin
        strobes.resSel.addImm = 1'b1;
        strobes.dstIdx        = fieldMid;
        strobes.writeEn       = instValid;
      end
      OP_HI_IM: begin
        strobes.resSel.hiImm = 1'b1;
        strobes.dstIdx       = fieldHi;
        strobes.writeEn      = instValid;
      end
      OP_ZX_IM: begin
        strobes.resSel.zeroImm = 1'b1;
        strobes.dstIdx         = fieldHi;
        strobes.writeEn        = instValid;
      end
      OP_MOVE: begin
        strobes.resSel.moveReg = 1'b1;
        strobes.dstIdx         = fieldHi;
        strobes.writeEn        = instValid;
      end
      default: ;
    endcase
    if (isRegReg) begin
      strobes.writeEn  = instValid && condPass;
      strobes.updZero  = instValid && condPass;
      strobes.updCarry = instValid && condPass && strobes.resSel.addRR;
    end
  end

endmodule

// File: rtl/cond_alu_dp.sv
module cond_alu_dp
  import cond_alu_pkg::*;
(
  input  res_sel_t             resSel,
  input  logic [IMM_L_W-1:0]   immField,
  input  logic [DATA_W-1:0]    opA,
  input  logic [DATA_W-1:0]    opB,
  output logic [DATA_W-1:0]    result,
  output logic                 carryOut
);

  localparam int SEXT_W = DATA_W - IMM_S_W;
  localparam int PAD_W  = DATA_W - IMM_L_W;

  logic [DATA_W-1:0] immShortSx;
  logic [DATA_W-1:0] immHiPlaced;
  logic [DATA_W-1:0] immZeroExt;
  logic [DATA_W-1:0] addend;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] nandVal;

  assign immShortSx  = {{SEXT_W{immField[IMM_S_W-1]}}, immField[IMM_S_W-1:0]};
  assign immHiPlaced = {immField, {PAD_W{1'b0}}};
  assign immZeroExt  = {{PAD_W{1'b0}}, immField};

  // One shared adder serves both add forms
  assign addend  = resSel.addImm ? immShortSx : opB;
  assign sumWide = {1'b0, opA} + {1'b0, addend};
  assign nandVal = ~(opA & opB);

  assign carryOut = sumWide[DATA_W];

  assign result = ({DATA_W{resSel.addRR | resSel.addImm}} & sumWide[DATA_W-1:0])
                | ({DATA_W{resSel.nandRR}}  & nandVal)
                | ({DATA_W{resSel.hiImm}}   & immHiPlaced)
                | ({DATA_W{resSel.zeroImm}} & immZeroExt)
                | ({DATA_W{resSel.moveReg}} & opB);

endmodule

// File: rtl/cond_alu_flags.sv
module cond_alu_flags
  import cond_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              updCarry,
  input  logic              updZero,
  input  logic              carryIn,
  input  logic [DATA_W-1:0] resultIn,
  output logic              carryFlag,
  output logic              zeroFlag
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryFlag <= 1'b0;
      zeroFlag  <= 1'b0;
    end else begin
      if (updCarry) carryFlag <= carryIn;
      if (updZero)  zeroFlag  <= ~|resultIn;
    end
  end

  p_carry_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !updCarry |=> $stable(carryFlag));

  p_zero_track_r9: assert property (@(posedge clk) disable iff (!rstN)
    updZero |=> (zeroFlag == ($past(resultIn) == '0)));

  p_zero_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !updZero |=> $stable(zeroFlag));

endmodule

// File: rtl/cond_alu_exec.sv
module cond_alu_exec
  import cond_alu_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  input  logic [15:0]         instWord,
  input  logic [15:0]         opA,
  input  logic [15:0]         opB,
  output logic [15:0]         result,
  output logic [2:0]          dstIdx,
  output logic                regWe,
  output logic                carryFlag,
  output logic                zeroFlag
);

  exec_strobes_t strobes;
  logic          carryOut;

  cond_alu_ctrl ctrl_i (
    .instValid (instValid),
    .instWord  (instWord),
    .carryFlag (carryFlag),
    .zeroFlag  (zeroFlag),
    .strobes   (strobes)
  );

  cond_alu_dp dp_i (
    .resSel   (strobes.resSel),
    .immField (instWord[IMM_L_W-1:0]),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .carryOut (carryOut)
  );

  cond_alu_flags flags_i (
    .clk       (clk),
    .rstN      (rstN),
    .updCarry  (strobes.updCarry),
    .updZero   (strobes.updZero),
    .carryIn   (carryOut),
    .resultIn  (result),
    .carryFlag (carryFlag),
    .zeroFlag  (zeroFlag)
  );

  assign dstIdx = strobes.dstIdx;
  assign regWe  = strobes.writeEn;

  logic isRR;
  assign isRR = (instWord[15:12] == 4'b0000) || (instWord[15:12] == 4'b0010);

  p_carry_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && isRR && instWord[1:0] == 2'b10 && !carryFlag) |-> !regWe);

  p_zero_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && isRR && instWord[1:0] == 2'b01 && !zeroFlag) |-> !regWe);

  p_hi_low_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instWord[15:12] == 4'b0011) |-> (regWe && result[6:0] == 7'd0));

  p_zext_top_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instWord[15:12] == 4'b1010) |-> (result[15:9] == 7'd0));

  p_idle_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !regWe);

  p_idle_flags_r10: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> ($stable(carryFlag) && $stable(zeroFlag)));

endmodule

// File: tb/cond_alu_exec_tb_top.sv
module cond_alu_exec_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instValid;
  logic [15:0] instWord;
  logic [15:0] opA;
  logic [15:0] opB;
  logic [15:0] result;
  logic [2:0]  dstIdx;
  logic        regWe;
  logic        carryFlag;
  logic        zeroFlag;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #10 clk = ~clk;

  cond_alu_exec dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .opA(opA), .opB(opB), .result(result), .dstIdx(dstIdx), .regWe(regWe),
    .carryFlag(carryFlag), .zeroFlag(zeroFlag)
  );

  // {word, opA, opB, result, checkResult, we, dst, carryAfter, zeroAfter}
  localparam int VW = 71;
  localparam int NV = 16;
  localparam logic [VW-1:0] VEC [NV] = '{
    {16'h0298, 16'h0003, 16'h0004, 16'h0007, 1'b1, 1'b1, 3'd3, 1'b0, 1'b0}, // R1 plain add
    {16'h029A, 16'h0001, 16'h0001, 16'h0002, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0}, // R3 carry clear, no write
    {16'h0298, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b1, 3'd3, 1'b1, 1'b1}, // R8 R9 wrap
    {16'h029A, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b1, 3'd3, 1'b1, 1'b1}, // R3 carry set, writes
    {16'h2298, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 3'd3, 1'b1, 1'b1}, // R2 nand keeps carry
    {16'h2299, 16'h00F0, 16'h0FF0, 16'hFF0F, 1'b1, 1'b1, 3'd3, 1'b1, 1'b0}, // R3 zero set, writes
    {16'h0299, 16'h0001, 16'h0002, 16'h0003, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0}, // R3 zero clear, no write
    {16'h229A, 16'h1234, 16'h0000, 16'hFFFF, 1'b1, 1'b1, 3'd3, 1'b1, 1'b0}, // R2 conditional on carry
    {16'h029B, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 1'b1, 3'd3, 1'b0, 1'b0}, // R3 code 11 always
    {16'h229A, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0}, // R3 nand blocked
    {16'h157E, 16'h0005, 16'h0000, 16'h0003, 1'b1, 1'b1, 3'd5, 1'b0, 1'b0}, // R4 negative imm
    {16'h155F, 16'h0001, 16'h0000, 16'h0020, 1'b1, 1'b1, 3'd5, 1'b0, 1'b0}, // R4 positive imm
    {16'h39FF, 16'h0000, 16'h0000, 16'hFF80, 1'b1, 1'b1, 3'd4, 1'b0, 1'b0}, // R5 high placement
    {16'hADAB, 16'h0000, 16'h0000, 16'h01AB, 1'b1, 1'b1, 3'd6, 1'b0, 1'b0}, // R6 zero extend
    {16'hB3C0, 16'h0000, 16'hBEEF, 16'hBEEF, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0}, // R7 move
    {16'h4000, 16'hFFFF, 16'h0001, 16'h0000, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0}  // R10 other opcode
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive on the falling edge, sample outputs 2 ns later, flags 2 ns after the rising edge
  task automatic runStep(input string tag, input logic v, input logic [15:0] w,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic chkRes, input logic [15:0] expRes,
                         input logic expWe, input logic [2:0] expDst,
                         input logic expC, input logic expZ);
    @(negedge clk);
    instValid = v; instWord = w; opA = a; opB = b;
    #2;
    if (chkRes) check({tag, " result"}, result, expRes);
    check({tag, " regWe"}, 16'(regWe), 16'(expWe));
    if (expWe) check({tag, " dstIdx"}, 16'(dstIdx), 16'(expDst));
    @(posedge clk);
    #2;
    check({tag, " carryFlag"}, 16'(carryFlag), 16'(expC));
    check({tag, " zeroFlag"}, 16'(zeroFlag), 16'(expZ));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checkCount++;
    failCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    rstN = 1'b0; instValid = 1'b0; instWord = '0; opA = '0; opB = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R11 reset carryFlag", 16'(carryFlag), 16'h0);
    check("R11 reset zeroFlag", 16'(zeroFlag), 16'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      e = VEC[i];
      runStep($sformatf("vector %0d", i), 1'b1, e[70:55], e[54:39], e[38:23],
              e[6], e[22:7], e[5], e[4:2], e[1], e[0]);
    end

    // R1: spare bit 2 set changes nothing
    runStep("R1 spare bit", 1'b1, 16'h029C, 16'h0002, 16'h0003, 1'b1, 16'h0005,
            1'b1, 3'd3, 1'b0, 1'b0);
    // R10: idle cycle with an overflowing add does not write or touch flags
    runStep("R10 idle", 1'b0, 16'h0298, 16'hFFFF, 16'h0001, 1'b0, 16'h0000,
            1'b0, 3'd0, 1'b0, 1'b0);
    // R8 R9: set both flags, then R11 asynchronous reset clears them
    runStep("R8 set flags", 1'b1, 16'h0298, 16'hFFFF, 16'h0001, 1'b1, 16'h0000,
            1'b1, 3'd3, 1'b1, 1'b1);
    @(negedge clk);
    instValid = 1'b0;
    #3;
    rstN = 1'b0;
    #2;
    check("R11 async carryFlag", 16'(carryFlag), 16'h0);
    check("R11 async zeroFlag", 16'(zeroFlag), 16'h0);
    @(negedge clk);
    rstN = 1'b1;
    // R3: zero flag cleared by reset blocks a zero-conditional add
    runStep("R3 after reset", 1'b1, 16'h0299, 16'h0004, 16'h0004, 1'b1, 16'h0008,
            1'b0, 3'd3, 1'b0, 1'b0);

    finish();
  end

endmodule